// File: doc/BRIEF.md
# Six-Channel Programmable Interval Timer Bank

This block holds six independent up-counting timers behind a small register bus with a combinational read path. Each channel has its own control, clock-setup, counter and compare registers. Software programs a compare value, picks an operating mode and starts the channel. The counter then advances on qualified ticks until it meets the compare value.

Two tick-enable inputs stand in for the two selectable timebases, a fast one and a slow one. Each channel can pick either input and can halve its count rate. All channels share one interrupt-enable register and one pending/acknowledge register, and together they drive a single interrupt line.

A channel runs in one of three modes. In one-shot mode it stops itself at the compare value. In repeat mode it reloads to zero at the compare value and keeps counting. In free-running mode it counts through the whole range and never raises an event.

Top module: `gpt_bank`

## Requirements
- R1: Register map. Offset 0x00 is the interrupt-enable register and offset 0x08 is the pending/acknowledge register; channel n (1..6) owns bit n-1 of both. Channel n has control at 0x10*n, clock setup at 0x10*n+0x04, counter at 0x10*n+0x08 and compare at 0x10*n+0x0C. Every other address, including 0x04, 0x0C and 0x70 and above, reads as zero and ignores writes.
- R2: Control register bits. Bit 0 is the enable and bits [5:4] are the mode. Writing bit 1 as 1 zeroes the counter at the clock edge of that write. Bit 1 always reads back as 0.
- R3: While enabled, the counter rises by one on each qualified tick. While disabled, it holds its value.
- R4: Clock-setup bit 4 selects the tick source: 0 is the fast tick and 1 is the slow tick. Clock-setup bit 0 set to 1 makes the channel count only on every second qualified tick. A clear write restarts that alternation.
- R5: Repeat mode (mode 1). A step that brings the counter to the compare value sets the channel's pending flag and reloads the counter to 0. The channel keeps counting.
- R6: One-shot mode (mode 0). A step that brings the counter to the compare value sets the pending flag, leaves the counter at the compare value and clears the channel's enable bit.
- R7: Free-running mode (mode 3) and the reserved mode 2 never set a pending flag. In these modes the counter wraps from all ones to zero.
- R8: Pending flags are recorded whether or not their enable bit is set, and they read back at offset 0x08. Writing 1 to a bit of 0x08 clears that flag. Writing 0 leaves it unchanged. A match in the same cycle as its acknowledge leaves the flag set.
- R9: The interrupt output is high exactly when some channel has both its pending flag and its interrupt-enable bit set.
- R10: The compare register can be written and read back at any time. Writes to the counter register are ignored.
- R11: Reset clears every enable, mode, clock-setup, compare, counter and pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_fast | input | 1 | Tick enable of the fast timebase |
| tick_slow | input | 1 | Tick enable of the slow timebase |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data of the addressed register, combinational |
| irq | output | 1 | Interrupt, OR of enabled pending flags |

## Verification
The bench builds the block with 8-bit counters, so that a free-running channel wraps within a few hundred ticks. A channel with the wrong range or with matching left on would leave a stray pending bit. The bench also checks the following:
- A repeat channel is stepped across its compare value. Reloading one step late, or not reloading, shows up as a wrong counter read.
- A one-shot channel must read back disabled with its count parked at the compare value.
- The divide-by-two path is run from a freshly cleared phase, which exposes an off-by-one in the alternation.
- An acknowledge lands in the same cycle as a match. A design that lets the acknowledge win drops the event.
- Writes to the counter register and acknowledge writes of zero bits are checked to change nothing.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    typedef enum logic [1:0] {
        MODE_ONESHOT = 2'd0,
        MODE_REPEAT  = 2'd1,
        MODE_RSVD    = 2'd2,
        MODE_FREERUN = 2'd3
    } gpt_mode_e;

    typedef struct packed {
        gpt_mode_e mode;
        logic      en;
    } gpt_ctrl_t;

    typedef struct packed {
        logic src_slow;
        logic div2;
    } gpt_clkcfg_t;

    // register slot within a channel page (address bits [3:2])
    localparam logic [1:0] SLOT_CTRL = 2'd0;
    localparam logic [1:0] SLOT_CLK  = 2'd1;
    localparam logic [1:0] SLOT_CNT  = 2'd2;
    localparam logic [1:0] SLOT_CMP  = 2'd3;

    // control / clock-setup bit positions
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CLR_BIT = 1;
    localparam int CTRL_MODE_LO = 4;
    localparam int CLK_DIV_BIT  = 0;
    localparam int CLK_SRC_BIT  = 4;

    function automatic logic mode_has_match(gpt_mode_e m);
        return (m == MODE_ONESHOT) || (m == MODE_REPEAT);
    endfunction

endpackage

// File: rtl/gpt_regdec.sv
module gpt_regdec #(
    parameter int ADDR_W = 8,
    parameter int NUM_CH = 6,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int PAGE_W = ADDR_W - 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic              sel_ien,
    output logic              sel_ack,
    output logic              ch_valid,
    output logic [CH_W-1:0]   ch_idx,
    output logic [1:0]        slot,
    output logic              ien_we,
    output logic              ack_we,
    output logic [NUM_CH-1:0] ctrl_we,
    output logic [NUM_CH-1:0] clk_we,
    output logic [NUM_CH-1:0] cmp_we
);
    import gpt_pkg::*;

    logic              aligned;
    logic [PAGE_W-1:0] page;
    logic [PAGE_W-1:0] page_m1;

    assign aligned  = (addr[1:0] == 2'b00);
    assign page     = addr[ADDR_W-1:4];
    assign page_m1  = page - PAGE_W'(1);
    assign slot     = addr[3:2];
    assign sel_ien  = aligned && (page == '0) && (slot == 2'd0);
    assign sel_ack  = aligned && (page == '0) && (slot == 2'd2);
    assign ch_valid = aligned && (page != '0) && (page <= PAGE_W'(NUM_CH));
    assign ch_idx   = page_m1[CH_W-1:0];
    assign ien_we   = we && sel_ien;
    assign ack_we   = we && sel_ack;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_we
        logic hit_ch;
        assign hit_ch     = we && ch_valid && (ch_idx == CH_W'(i));
        assign ctrl_we[i] = hit_ch && (slot == SLOT_CTRL);
        assign clk_we[i]  = hit_ch && (slot == SLOT_CLK);
        assign cmp_we[i]  = hit_ch && (slot == SLOT_CMP);
    end

endmodule

// File: rtl/gpt_channel.sv
module gpt_channel #(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_fast,
    input  logic                tick_slow,
    input  logic                ctrl_we,
    input  logic                clk_we,
    input  logic                cmp_we,
    input  logic [DATA_W-1:0]   wdata,
    output gpt_pkg::gpt_ctrl_t   ctrl_q,
    output gpt_pkg::gpt_clkcfg_t clkcfg_q,
    output logic [CNT_W-1:0]    cnt_q,
    output logic [CNT_W-1:0]    cmp_q,
    output logic                hit
);
    import gpt_pkg::*;

    logic             phase_q;
    logic             tick_sel;
    logic             qual;
    logic             step;
    logic [CNT_W-1:0] cnt_inc;

    assign tick_sel = clkcfg_q.src_slow ? tick_slow : tick_fast;
    assign qual     = ctrl_q.en && tick_sel && !ctrl_we;
    assign step     = qual && (!clkcfg_q.div2 || phase_q);
    assign cnt_inc  = cnt_q + CNT_W'(1);
    assign hit      = step && mode_has_match(ctrl_q.mode) && (cnt_inc == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            clkcfg_q <= '0;
            cnt_q    <= '0;
            cmp_q    <= '0;
            phase_q  <= 1'b0;
        end else begin
            if (ctrl_we) begin
                ctrl_q.en   <= wdata[CTRL_EN_BIT];
                ctrl_q.mode <= gpt_mode_e'(wdata[CTRL_MODE_LO+1:CTRL_MODE_LO]);
                if (wdata[CTRL_CLR_BIT]) begin
                    cnt_q   <= '0;
                    phase_q <= 1'b0;
                end
            end else begin
                if (qual && clkcfg_q.div2) begin
                    phase_q <= ~phase_q;
                end
                if (step) begin
                    if (hit && (ctrl_q.mode == MODE_REPEAT)) begin
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_inc;
                    end
                    if (hit && (ctrl_q.mode == MODE_ONESHOT)) begin
                        ctrl_q.en <= 1'b0;
                    end
                end
            end
            if (clk_we) begin
                clkcfg_q.src_slow <= wdata[CLK_SRC_BIT];
                clkcfg_q.div2     <= wdata[CLK_DIV_BIT];
            end
            if (cmp_we) begin
                cmp_q <= wdata[CNT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/gpt_irq_ctrl.sv
module gpt_irq_ctrl #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ien_we,
    input  logic              ack_we,
    input  logic [NUM_CH-1:0] wbits,
    input  logic [NUM_CH-1:0] hit,
    output logic [NUM_CH-1:0] ien_q,
    output logic [NUM_CH-1:0] pend_q,
    output logic              irq
);
    logic [NUM_CH-1:0] ack_mask;

    assign ack_mask = ack_we ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q  <= '0;
            pend_q <= '0;
        end else begin
            if (ien_we) begin
                ien_q <= wbits;
            end
            // a new match outranks an acknowledge in the same cycle
            pend_q <= (pend_q & ~ack_mask) | hit;
        end
    end

    assign irq = |(pend_q & ien_q);

endmodule

// File: rtl/gpt_bank.sv
module gpt_bank #(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_fast,
    input  logic              tick_slow,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    import gpt_pkg::*;

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic              sel_ien, sel_ack, ch_valid;
    logic [CH_W-1:0]   ch_idx;
    logic [1:0]        slot;
    logic              ien_we, ack_we;
    logic [NUM_CH-1:0] ctrl_we, clk_we, cmp_we;
    logic [NUM_CH-1:0] ien_q, pend_q, hit_vec;
    logic [NUM_CH-1:0] en_vec, os_vec, nm_vec;
    logic [NUM_CH*CNT_W-1:0] cnt_flat;

    gpt_ctrl_t        ctrl_arr   [NUM_CH];
    gpt_clkcfg_t      clkcfg_arr [NUM_CH];
    logic [CNT_W-1:0] cnt_arr    [NUM_CH];
    logic [CNT_W-1:0] cmp_arr    [NUM_CH];

    gpt_regdec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
        .addr(bus_addr), .we(bus_we),
        .sel_ien(sel_ien), .sel_ack(sel_ack), .ch_valid(ch_valid),
        .ch_idx(ch_idx), .slot(slot), .ien_we(ien_we), .ack_we(ack_we),
        .ctrl_we(ctrl_we), .clk_we(clk_we), .cmp_we(cmp_we)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        gpt_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
            .clk(clk), .rst(rst),
            .tick_fast(tick_fast), .tick_slow(tick_slow),
            .ctrl_we(ctrl_we[i]), .clk_we(clk_we[i]), .cmp_we(cmp_we[i]),
            .wdata(bus_wdata),
            .ctrl_q(ctrl_arr[i]), .clkcfg_q(clkcfg_arr[i]),
            .cnt_q(cnt_arr[i]), .cmp_q(cmp_arr[i]), .hit(hit_vec[i])
        );
        assign en_vec[i] = ctrl_arr[i].en;
        assign os_vec[i] = (ctrl_arr[i].mode == MODE_ONESHOT);
        assign nm_vec[i] = !mode_has_match(ctrl_arr[i].mode);
        assign cnt_flat[i*CNT_W +: CNT_W] = cnt_arr[i];
    end

    gpt_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
        .clk(clk), .rst(rst),
        .ien_we(ien_we), .ack_we(ack_we),
        .wbits(bus_wdata[NUM_CH-1:0]), .hit(hit_vec),
        .ien_q(ien_q), .pend_q(pend_q), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_ien) begin
            bus_rdata[NUM_CH-1:0] = ien_q;
        end else if (sel_ack) begin
            bus_rdata[NUM_CH-1:0] = pend_q;
        end else if (ch_valid) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_idx == CH_W'(i)) begin
                    unique case (slot)
                        SLOT_CTRL: begin
                            bus_rdata[CTRL_EN_BIT] = ctrl_arr[i].en;
                            bus_rdata[CTRL_MODE_LO+1:CTRL_MODE_LO] = ctrl_arr[i].mode;
                        end
                        SLOT_CLK: begin
                            bus_rdata[CLK_SRC_BIT] = clkcfg_arr[i].src_slow;
                            bus_rdata[CLK_DIV_BIT] = clkcfg_arr[i].div2;
                        end
                        SLOT_CNT: bus_rdata[CNT_W-1:0] = cnt_arr[i];
                        default:  bus_rdata[CNT_W-1:0] = cmp_arr[i];
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/gpt_bank_chk.sv
module gpt_bank_chk #(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    irq,
    input logic [NUM_CH-1:0]       ien,
    input logic [NUM_CH-1:0]       pend,
    input logic [NUM_CH-1:0]       hit,
    input logic [NUM_CH-1:0]       en,
    input logic [NUM_CH-1:0]       oneshot,
    input logic [NUM_CH-1:0]       nomatch,
    input logic [NUM_CH-1:0]       ctrl_we,
    input logic                    wr_clear,
    input logic [NUM_CH*CNT_W-1:0] cnt_flat
);
    // R9: interrupt never rises with every enable bit low
    p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ien != '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R8: a match always leaves the pending flag set
        p_pend_after_hit_r8: assert property (@(posedge clk) disable iff (rst)
            hit[i] |=> pend[i]);
        // R6: one-shot match drops the enable
        p_oneshot_halts_r6: assert property (@(posedge clk) disable iff (rst)
            (hit[i] && oneshot[i]) |=> !en[i]);
        // R7: free-running and reserved modes raise no match
        p_freerun_no_hit_r7: assert property (@(posedge clk) disable iff (rst)
            nomatch[i] |-> !hit[i]);
        // R3: a disabled channel holds its count unless its control is written
        p_hold_disabled_r3: assert property (@(posedge clk) disable iff (rst)
            (!en[i] && !ctrl_we[i]) |=> $stable(cnt_flat[i*CNT_W +: CNT_W]));
        // R2: clear bit zeroes the counter at the write edge
        p_clear_zero_r2: assert property (@(posedge clk) disable iff (rst)
            (ctrl_we[i] && wr_clear) |=> (cnt_flat[i*CNT_W +: CNT_W] == '0));
    end

endmodule

bind gpt_bank gpt_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .irq(irq), .ien(ien_q), .pend(pend_q),
    .hit(hit_vec), .en(en_vec), .oneshot(os_vec), .nomatch(nm_vec),
    .ctrl_we(ctrl_we), .wr_clear(bus_wdata[1]), .cnt_flat(cnt_flat)
);

// File: tb/gpt_bank_tb.sv
module gpt_bank_tb;

    localparam int NUM_CH = 6;
    localparam int CNT_W  = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    typedef enum logic [2:0] {K_WR, K_RD, K_FAST, K_SLOW, K_IRQ} kind_e;
    typedef struct packed {
        kind_e       kind;
        logic [7:0]  addr;
        logic [31:0] data;   // write data, tick count or expected value
        logic [3:0]  req;
    } vec_t;

    localparam int VEC_N = 45;
    localparam vec_t VEC [VEC_N] = '{
        '{K_RD,   8'h00, 32'h00, 4'd11}, // R11 enables clear
        '{K_RD,   8'h18, 32'h00, 4'd11}, // R11 counter clear
        '{K_WR,   8'h1C, 32'h05, 4'd10},
        '{K_RD,   8'h1C, 32'h05, 4'd10}, // R10 compare readback
        '{K_WR,   8'h10, 32'h13, 4'd2},
        '{K_RD,   8'h10, 32'h11, 4'd2},  // R2 clear bit reads 0
        '{K_FAST, 8'h00, 32'd3,  4'd3},
        '{K_RD,   8'h18, 32'h03, 4'd3},  // R3 counts up
        '{K_FAST, 8'h00, 32'd2,  4'd5},
        '{K_RD,   8'h18, 32'h00, 4'd5},  // R5 reload at compare
        '{K_RD,   8'h08, 32'h01, 4'd8},  // R8 pending without enable
        '{K_IRQ,  8'h00, 32'h00, 4'd9},  // R9 masked
        '{K_WR,   8'h00, 32'h01, 4'd9},
        '{K_IRQ,  8'h00, 32'h01, 4'd9},  // R9 unmasked
        '{K_WR,   8'h08, 32'h3E, 4'd8},
        '{K_RD,   8'h08, 32'h01, 4'd8},  // R8 zero bits leave flag
        '{K_WR,   8'h08, 32'h3F, 4'd8},
        '{K_RD,   8'h08, 32'h00, 4'd8},  // R8 ack clears
        '{K_FAST, 8'h00, 32'd7,  4'd5},
        '{K_RD,   8'h18, 32'h02, 4'd5},  // R5 keeps running after reload
        '{K_WR,   8'h10, 32'h10, 4'd3},
        '{K_FAST, 8'h00, 32'd4,  4'd3},
        '{K_RD,   8'h18, 32'h02, 4'd3},  // R3 holds when disabled
        '{K_WR,   8'h18, 32'h55, 4'd10},
        '{K_RD,   8'h18, 32'h02, 4'd10}, // R10 counter write ignored
        '{K_WR,   8'h2C, 32'h03, 4'd6},
        '{K_WR,   8'h20, 32'h03, 4'd6},
        '{K_FAST, 8'h00, 32'd5,  4'd6},
        '{K_RD,   8'h28, 32'h03, 4'd6},  // R6 parks at compare
        '{K_RD,   8'h20, 32'h00, 4'd6},  // R6 enable dropped
        '{K_RD,   8'h08, 32'h03, 4'd6},  // R6 pending set
        '{K_WR,   8'h34, 32'h10, 4'd4},
        '{K_WR,   8'h30, 32'h33, 4'd4},
        '{K_FAST, 8'h00, 32'd4,  4'd4},
        '{K_RD,   8'h38, 32'h00, 4'd4},  // R4 ignores fast tick
        '{K_SLOW, 8'h00, 32'd3,  4'd4},
        '{K_RD,   8'h38, 32'h03, 4'd4},  // R4 slow source
        '{K_WR,   8'h34, 32'h11, 4'd4},
        '{K_SLOW, 8'h00, 32'd5,  4'd4},
        '{K_RD,   8'h38, 32'h05, 4'd4},  // R4 divide by two
        '{K_RD,   8'h04, 32'h00, 4'd1},  // R1 unmapped
        '{K_RD,   8'h70, 32'h00, 4'd1},  // R1 beyond last channel
        '{K_RD,   8'h0C, 32'h00, 4'd1},  // R1 unmapped
        '{K_WR,   8'h6C, 32'h2A, 4'd1},
        '{K_RD,   8'h6C, 32'h2A, 4'd1}   // R1 channel 6 page
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_fast = 1'b0;
    logic              tick_slow = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    gpt_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .tick_fast(tick_fast), .tick_slow(tick_slow),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        tick_fast = 0; tick_slow = 0;
        bus_we = 1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic bus_read(input int req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        tick_fast = 0; tick_slow = 0; bus_we = 0; bus_addr = a;
        #1 check(req, bus_rdata, exp);
    endtask

    task automatic ticks(input bit slow, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bus_we = 0;
            tick_fast = !slow; tick_slow = slow;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        for (int v = 0; v < VEC_N; v++) begin
            unique case (VEC[v].kind)
                K_WR:   bus_write(VEC[v].addr, VEC[v].data);
                K_RD:   bus_read(int'(VEC[v].req), VEC[v].addr, VEC[v].data);
                K_FAST: ticks(1'b0, int'(VEC[v].data));
                K_SLOW: ticks(1'b1, int'(VEC[v].data));
                default: begin
                    @(negedge clk);
                    bus_we = 0; tick_fast = 0; tick_slow = 0;
                    #1 check(int'(VEC[v].req), {31'b0, irq}, VEC[v].data);
                end
            endcase
        end

        // R4 clock-setup readback
        bus_read(4, 8'h34, 32'h11);

        // R7: free-run on channel 4, reserved mode 2 on channel 5 with a reachable compare
        bus_write(8'h5C, 32'h01);
        bus_write(8'h50, 32'h23);
        bus_write(8'h40, 32'h33);
        ticks(1'b0, 255);
        bus_read(7, 8'h48, 32'hFF);
        ticks(1'b0, 1);
        bus_read(7, 8'h48, 32'h00);   // R7 wrap
        bus_read(7, 8'h58, 32'h00);   // R7 reserved mode wraps too
        bus_read(7, 8'h08, 32'h03);   // R7 no new pending

        // R8: match and acknowledge in the same cycle
        bus_write(8'h08, 32'h3F);
        bus_write(8'h10, 32'h13);
        ticks(1'b0, 4);
        @(negedge clk);
        tick_fast = 1; tick_slow = 0;
        bus_we = 1; bus_addr = 8'h08; bus_wdata = 32'h01;
        bus_read(8, 8'h08, 32'h01);   // R8 match wins
        bus_read(5, 8'h18, 32'h00);   // R5 reloaded

        // R11: reset in mid-run
        bus_write(8'h00, 32'h3F);
        @(negedge clk);
        bus_we = 0;
        rst = 1;
        @(negedge clk);
        rst = 0;
        bus_read(11, 8'h00, 32'h00);
        bus_read(11, 8'h08, 32'h00);
        bus_read(11, 8'h38, 32'h00);
        bus_read(11, 8'h6C, 32'h00);
        bus_read(11, 8'h34, 32'h00);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule